// File: doc/BRIEF.md
# Sample FIFO with Watermark

This block is a synchronous first-in first-out store for 16-bit sensor samples. It has a push port with a valid strobe and a pop port that shows the oldest held sample at all times. The block reports its fill level, a full flag and a watermark flag. The threshold is a 12-bit value counted in whole samples, so one unit is one 16-bit word, or two bytes.

Four buffering modes are available. Bypass keeps the store empty. Stop-when-full refuses new samples once the store is full. Continuous overwrites the oldest sample. The armed mode behaves as bypass until a trigger arrives and then as continuous.

The threshold also has a second use. When the stop-at-threshold enable is set, the threshold becomes the capacity of the store, and the full flag and write refusal act at that level instead of at the physical depth of 4096 samples. With the enable clear, the watermark flag rises when the threshold is reached while storage carries on to physical full.

Top module: `sample_fifo_wm`

## Requirements
- R1: `wm_flag` is 1 exactly when `level` >= `threshold` (0..4095, in samples). It changes in the same cycle as the `level` change that crosses the threshold, so a threshold of 0 gives `wm_flag`=1 even when the store is empty.
- R2: With `stop_at_th`=0 the capacity is 4096. `full_flag` is 1 only at `level`=4096, and reaching the watermark does not stop writes.
- R3: With `stop_at_th`=1 the capacity equals `threshold`, and `full_flag` is 1 whenever `level` >= `threshold`.
- R4: In stop-when-full mode (`mode`=2'b01), a push into a full store without a pop is dropped. Both `level` and the contents stay unchanged.
- R5: In continuous mode (`mode`=2'b10), a push into a full, non-empty store without a pop discards the oldest sample. `level` is unchanged and the head moves to the next-oldest sample.
- R6: In bypass mode (`mode`=2'b00), `level` is 0 from the next cycle onward, and pushes and pops are ignored.
- R7: In armed mode (`mode`=2'b11), the store acts as bypass until `trig` is seen high at a clock edge, and acts as continuous from the next cycle on. Any other mode value re-arms it.
- R8: A pop while `level`=0 is ignored.
- R9: A push and a pop in the same cycle on a store that is neither empty nor full leave `level` unchanged and keep the order of the samples.
- R10: When `level`>0, `rd_data` shows the oldest held sample, and a pop moves it to the next one.
- R11: After reset `level` is 0, so with a nonzero threshold both flags are 0.
- R12: Both flags drop as soon as pops bring `level` below the threshold or the capacity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Push strobe for `wr_data` |
| wr_data | input | 16 | Sample to store |
| rd_pop | input | 1 | Removes the head sample |
| rd_data | output | 16 | Oldest held sample, valid when `level`>0 |
| threshold | input | 12 | Watermark level in samples |
| stop_at_th | input | 1 | 1: capacity is limited to `threshold` |
| mode | input | 2 | 00 bypass, 01 stop-when-full, 10 continuous, 11 armed bypass-to-continuous |
| trig | input | 1 | Trigger that moves armed mode into continuous |
| level | output | 13 | Number of samples held (0..4096) |
| wm_flag | output | 1 | Watermark reached |
| full_flag | output | 1 | Effective capacity reached |

## Verification
The properties assume that `mode`, `threshold` and `stop_at_th` are changed only between pushes, and that `wr_valid`, `rd_pop` and `trig` are clean single-cycle strobes sampled at the rising edge. The bench changes configuration only while both strobes are low, and it applies every strobe on the falling edge for exactly one cycle. This keeps each property's premise tied to a single accepted or refused operation. The cases where the threshold is lowered below the current level are not relied on by any property except the level bound.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  typedef enum logic [1:0] {
    SFW_BYPASS = 2'b00,
    SFW_STOP   = 2'b01,
    SFW_STREAM = 2'b10,
    SFW_ARMED  = 2'b11
  } sfw_mode_e;
endpackage

// File: rtl/sfw_store.sv
module sfw_store #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfw_occupancy.sv
module sfw_occupancy
  import sfw_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sfw_mode_e     mode_i,
  input  logic          trig,
  input  logic          wr_valid,
  input  logic          rd_pop,
  input  logic          full,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW:0]   count,
  output logic          ev_hold,
  output logic          ev_accept,
  output logic          ev_pop,
  output logic          ev_discard
);
  localparam int CW = AW + 1;

  logic armed;
  logic overwrite;
  logic has_data;
  logic room;

  // Net change of the count for one cycle; kept in a function for clarity.
  function automatic logic [CW-1:0] next_count(logic [CW-1:0] c, logic add, logic sub, logic drop);
    return c + CW'(add) - CW'(sub) - CW'(drop);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed <= 1'b0;
    else if (mode_i != SFW_ARMED) armed <= 1'b0;
    else if (trig)               armed <= 1'b1;
  end

  assign ev_hold    = (mode_i == SFW_BYPASS) || ((mode_i == SFW_ARMED) && !armed);
  assign overwrite  = (mode_i == SFW_STREAM) || ((mode_i == SFW_ARMED) && armed);
  assign has_data   = (count != '0);
  assign ev_pop     = !ev_hold && rd_pop && has_data;
  assign room       = !full || ev_pop;
  assign ev_accept  = !ev_hold && wr_valid && (room || (overwrite && has_data));
  assign ev_discard = ev_accept && !room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (ev_hold) begin
      rd_ptr <= wr_ptr;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(ev_accept);
      rd_ptr <= rd_ptr + AW'(ev_pop || ev_discard);
      count  <= next_count(count, ev_accept, ev_pop, ev_discard);
    end
  end
endmodule

// File: rtl/sfw_flags.sv
module sfw_flags #(
  parameter int AW = 12,
  parameter int TW = 12
) (
  input  logic [AW:0]   count,
  input  logic [TW-1:0] threshold,
  input  logic          stop_at_th,
  output logic          wm,
  output logic          full
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [CW-1:0] capacity(logic stop, logic [TW-1:0] th);
    return stop ? CW'(th) : CW'(DEPTH);
  endfunction

  function automatic logic reached(logic [CW-1:0] c, logic [CW-1:0] lim);
    return c >= lim;
  endfunction

  assign wm   = reached(count, CW'(threshold));
  assign full = reached(count, capacity(stop_at_th, threshold));
endmodule

// File: rtl/sample_fifo_wm.sv
module sample_fifo_wm
  import sfw_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  input  logic [TW-1:0] threshold,
  input  logic          stop_at_th,
  input  logic [1:0]    mode,
  input  logic          trig,
  output logic [AW:0]   level,
  output logic          wm_flag,
  output logic          full_flag
);
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW:0]   count;
  logic          ev_hold;
  logic          ev_accept;
  logic          ev_pop;
  logic          ev_discard;
  sfw_mode_e     mode_e;

  assign mode_e = sfw_mode_e'(mode);

  sfw_occupancy #(.AW(AW)) u_occ (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_e),
    .trig       (trig),
    .wr_valid   (wr_valid),
    .rd_pop     (rd_pop),
    .full       (full_flag),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .count      (count),
    .ev_hold    (ev_hold),
    .ev_accept  (ev_accept),
    .ev_pop     (ev_pop),
    .ev_discard (ev_discard)
  );

  sfw_store #(.DW(DW), .AW(AW)) u_store (
    .clk   (clk),
    .we    (ev_accept),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  sfw_flags #(.AW(AW), .TW(TW)) u_flags (
    .count      (count),
    .threshold  (threshold),
    .stop_at_th (stop_at_th),
    .wm         (wm_flag),
    .full       (full_flag)
  );

  assign level = count;
endmodule

// File: rtl/sfw_checker.sv
module sfw_checker #(
  parameter int AW = 12,
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          rd_pop,
  input logic [TW-1:0] threshold,
  input logic          stop_at_th,
  input logic [1:0]    mode,
  input logic [AW:0]   level,
  input logic          wm_flag,
  input logic          full_flag,
  input logic          ev_hold,
  input logic          ev_accept,
  input logic          ev_pop
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  p_wm_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wm_flag == (level >= CW'(threshold)));

  p_cap_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_at_th && (level >= CW'(threshold))) |-> full_flag);

  p_hold_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> (level == '0));  // R7 too: armed mode before trigger

  p_stop_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b01) && full_flag && wr_valid && !rd_pop) |=> $stable(level));

  p_stream_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b10) && full_flag && wr_valid && !rd_pop && (level != '0)) |=> $stable(level));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((level == '0) && rd_pop) |-> !ev_pop);

  p_pushpop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_hold && ev_accept && ev_pop && !full_flag) |=> $stable(level));
endmodule

bind sample_fifo_wm sfw_checker #(.AW(AW), .TW(TW)) u_sfw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .rd_pop     (rd_pop),
  .threshold  (threshold),
  .stop_at_th (stop_at_th),
  .mode       (mode),
  .level      (level),
  .wm_flag    (wm_flag),
  .full_flag  (full_flag),
  .ev_hold    (ev_hold),
  .ev_accept  (ev_accept),
  .ev_pop     (ev_pop)
);

// File: tb/sample_fifo_wm_bench.sv
module sample_fifo_wm_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_pop = 1'b0;
  logic [15:0] rd_data;
  logic [11:0] threshold = 12'd3;
  logic        stop_at_th = 1'b1;
  logic [1:0]  mode = 2'b01;
  logic        trig = 1'b0;
  logic [12:0] level;
  logic        wm_flag;
  logic        full_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_fifo_wm u_sample_fifo_wm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .threshold(threshold),
    .stop_at_th(stop_at_th), .mode(mode), .trig(trig), .level(level),
    .wm_flag(wm_flag), .full_flag(full_flag)
  );

  typedef struct packed {
    logic        push;
    logic        pop;
    logic [15:0] din;
    logic [12:0] lvl;
    logic        wm;
    logic        full;
    logic [15:0] head;
  } vec_t;

  // Stop-when-full mode, stop_at_th=1, threshold=3 (capacity 3 samples).
  localparam vec_t TAB [9] = '{
    '{1'b1, 1'b0, 16'hA001, 13'd1, 1'b0, 1'b0, 16'hA001},
    '{1'b1, 1'b0, 16'hA002, 13'd2, 1'b0, 1'b0, 16'hA001},
    '{1'b1, 1'b0, 16'hA003, 13'd3, 1'b1, 1'b1, 16'hA001},
    '{1'b1, 1'b0, 16'hA004, 13'd3, 1'b1, 1'b1, 16'hA001},
    '{1'b0, 1'b1, 16'h0000, 13'd2, 1'b0, 1'b0, 16'hA002},
    '{1'b1, 1'b1, 16'hA005, 13'd2, 1'b0, 1'b0, 16'hA003},
    '{1'b0, 1'b1, 16'h0000, 13'd1, 1'b0, 1'b0, 16'hA005},
    '{1'b0, 1'b1, 16'h0000, 13'd0, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 1'b1, 16'h0000, 13'd0, 1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic q, input logic [15:0] d);
    @(negedge clk);
    wr_valid = p; rd_pop = q; wr_data = d;
    @(posedge clk);
    #1;
    wr_valid = 1'b0; rd_pop = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 level", 32'(level), 0);
    chk("R11 wm", 32'(wm_flag), 0);
    chk("R11 full", 32'(full_flag), 0);

    // Table walk: R3 R4 R8 R9 R10 R12
    foreach (TAB[i]) begin
      step(TAB[i].push, TAB[i].pop, TAB[i].din);
      chk($sformatf("R3/R4/R8/R9 row%0d level", i), 32'(level), 32'(TAB[i].lvl));
      chk($sformatf("R1/R12 row%0d wm", i), 32'(wm_flag), 32'(TAB[i].wm));
      chk($sformatf("R3/R12 row%0d full", i), 32'(full_flag), 32'(TAB[i].full));
      if (TAB[i].lvl != 0)
        chk($sformatf("R10 row%0d head", i), 32'(rd_data), 32'(TAB[i].head));
    end

    // R5: continuous overwrite at threshold capacity
    mode = 2'b10; threshold = 12'd2; stop_at_th = 1'b1;
    step(1, 0, 16'hB001);
    step(1, 0, 16'hB002);
    step(1, 0, 16'hB003);
    chk("R5 level", 32'(level), 2);
    chk("R5 full", 32'(full_flag), 1);
    chk("R5 head", 32'(rd_data), 32'h0000B002);
    step(0, 1, 0);
    step(0, 1, 0);
    chk("R8 drained", 32'(level), 0);

    // R1 boundary: threshold 0 means watermark on an empty store
    threshold = 12'd0; stop_at_th = 1'b0;
    @(negedge clk);
    chk("R1 th0 wm", 32'(wm_flag), 1);

    // R1/R2: watermark at 21 without stopping
    mode = 2'b01; threshold = 12'd21;
    for (int i = 0; i < 20; i++) step(1, 0, 16'(i));
    chk("R1 wm below", 32'(wm_flag), 0);
    step(1, 0, 16'd20);
    chk("R1 wm at 21", 32'(wm_flag), 1);
    chk("R2 not full at 21", 32'(full_flag), 0);
    step(1, 0, 16'd21);
    chk("R2 continues past 21", 32'(level), 22);
    step(0, 1, 0);
    step(0, 1, 0);
    chk("R12 wm clears", 32'(wm_flag), 0);
    chk("R10 head after pops", 32'(rd_data), 2);
    for (int i = 0; i < 20; i++) step(0, 1, 0);
    chk("R8 empty again", 32'(level), 0);

    // R2/R4: physical capacity 4096 in stop-when-full mode
    threshold = 12'd4095;
    for (int i = 0; i < 4097; i++) step(1, 0, 16'(i));
    chk("R2 level 4096", 32'(level), 4096);
    chk("R2 full", 32'(full_flag), 1);
    chk("R4 head kept", 32'(rd_data), 0);

    // R5 at physical full
    mode = 2'b10;
    step(1, 0, 16'hFFFF);
    chk("R5 level kept", 32'(level), 4096);
    chk("R5 oldest dropped", 32'(rd_data), 1);

    // R6: bypass empties and ignores pushes
    mode = 2'b00;
    step(0, 0, 0);
    chk("R6 emptied", 32'(level), 0);
    chk("R6 full clear", 32'(full_flag), 0);
    step(1, 0, 16'h1234);
    chk("R6 push ignored", 32'(level), 0);

    // R7: armed bypass-to-continuous
    mode = 2'b11;
    step(1, 0, 16'hD000);
    chk("R7 before trigger", 32'(level), 0);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    step(1, 0, 16'hD001);
    chk("R7 after trigger", 32'(level), 1);
    chk("R7 head", 32'(rd_data), 32'h0000D001);
    mode = 2'b00;
    step(0, 0, 0);
    mode = 2'b11;
    step(1, 0, 16'hD002);
    chk("R7 rearmed", 32'(level), 0);

    done = 1'b1;
    summary();
  end
endmodule